// File: doc/BRIEF.md
# Periodic Interrupt Modulus Counter

This block divides a 1/100 s tick into a programmable interrupt period. An 8-bit count advances by one on each tick. When the advance would make the count equal to the programmed modulus, the block emits a one-cycle interrupt request and restarts the count from zero. With a modulus of M, a request therefore arrives every M ticks.

A register port with one shared address reaches the block. A write stores the modulus, which cannot be read back. A read returns the live count, which cannot be written. After reset the block is idle: the modulus is zero and the count is parked at zero. A non-zero write starts it. A zero write suppresses requests from that very cycle. The count then keeps running until it rolls over to zero, which takes at most 255 ticks (2.55 s), and parks there.

The controller has three states:
- `PIM_IDLE`: parked, ticks ignored.
- `PIM_RUN`: counting and comparing.
- `PIM_DRAIN`: counting toward rollover with no requests.

The transitions are:
- start: IDLE→RUN on a non-zero write.
- stop: RUN→DRAIN on a zero write with a non-zero count after the edge.
- halt: RUN→IDLE on a zero write with the count zero after the edge.
- park: DRAIN→IDLE when a tick rolls 255 over to 0.
- resume: DRAIN→RUN on a non-zero write.

A write takes effect in the cycle in which it is presented. The compare and the next state both use the written value.

Top module: `pim_periodic_irq`

## Requirements
- R1: After reset, `irq_o` is low and a read returns 0.
- R2: `rdata_o` equals the count while `rd_en_i` is high and is 0 otherwise. A modulus write never changes the count.
- R3: While running or draining, each tick raises the count by one (255 rolls over to 0). Without a tick the count holds.
- R4: With non-zero modulus M, the tick whose increment would give M sets the count to 0. That tick also drives `irq_o` high for exactly the following cycle, so requests recur every M ticks.
- R5: Before any non-zero modulus write, ticks leave the count at 0 and raise no request.
- R6: A zero write suppresses any request from that cycle on. Later ticks keep incrementing the count until it rolls over to 0, and the count then stays at 0.
- R7: A zero write while the count is 0 stops counting at once.
- R8: A new non-zero modulus written while running does not clear the count. If the count is already at or above the new value, the count passes through 255 and 0 before it matches.
- R9: A non-zero write while draining resumes comparing from the current count without clearing it.
- R10: A modulus of 1 gives a request on every tick, with the count staying 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle 1/100 s advance strobe |
| wr_en_i | input | 1 | Modulus write strobe |
| rd_en_i | input | 1 | Count read strobe |
| wdata_i | input | 8 | Modulus value to write |
| rdata_o | output | 8 | Count value while reading, else 0 |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
The assertions check several rules on every cycle:
- the count only moves on a tick, and then only by one or to zero;
- the parked state always holds a zero count;
- a request only follows a tick and always leaves a zero count;
- a zero write is never followed by a request.

Some behaviours need whole tick histories and only the bench scenarios can show them:
- the exact period for a given modulus;
- rollover through 255 after retargeting to a smaller modulus;
- the drain length after a stop;
- resumption without a clear.

// File: rtl/pim_pkg.sv
package pim_pkg;
    localparam int PIM_CNT_W = 8;

    typedef enum logic [1:0] {
        PIM_IDLE  = 2'd0,
        PIM_RUN   = 2'd1,
        PIM_DRAIN = 2'd2
    } pim_state_e;
endpackage

// File: rtl/pim_modreg.sv
module pim_modreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] eff_mod_o,
    output logic         eff_zero_o
);
    logic [W-1:0] mod_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_q <= '0;
        end else if (wr_en_i) begin
            mod_q <= wdata_i;
        end
    end

    // A write is honoured in the cycle it is presented.
    always_comb begin
        eff_mod_o  = wr_en_i ? wdata_i : mod_q;
        eff_zero_o = (eff_mod_o == '0);
    end
endmodule

// File: rtl/pim_counter.sv
module pim_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv_i,
    input  logic [W-1:0] eff_mod_i,
    input  logic         eff_zero_i,
    output logic [W-1:0] cnt_o,
    output logic         cnt_zero_o,
    output logic         match_o,
    output logic         wrap_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_inc;

    always_comb begin
        cnt_inc    = cnt_q + {{(W-1){1'b0}}, 1'b1};
        match_o    = !eff_zero_i && (cnt_inc == eff_mod_i);
        wrap_o     = (cnt_inc == '0);
        cnt_zero_o = (cnt_q == '0);
        cnt_o      = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (adv_i) begin
            cnt_q <= match_o ? '0 : cnt_inc;
        end
    end
endmodule

// File: rtl/pim_fsm.sv
module pim_fsm
    import pim_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       eff_zero_i,
    input  logic       cnt_zero_i,
    input  logic       match_i,
    input  logic       wrap_i,
    output pim_state_e state_o,
    output logic       adv_o,
    output logic       irq_o
);
    pim_state_e state_q;
    pim_state_e state_d;
    logic       irq_q;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIM_IDLE: begin
                if (!eff_zero_i) state_d = PIM_RUN;          // start
            end
            PIM_RUN: begin
                if (eff_zero_i) begin
                    if (adv_o ? wrap_i : cnt_zero_i)
                        state_d = PIM_IDLE;                  // halt
                    else
                        state_d = PIM_DRAIN;                 // stop
                end
            end
            PIM_DRAIN: begin
                if (!eff_zero_i)
                    state_d = PIM_RUN;                       // resume
                else if (adv_o && wrap_i)
                    state_d = PIM_IDLE;                      // park
            end
            default: state_d = PIM_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIM_IDLE;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= adv_o && match_i;
        end
    end

    // Outputs.
    always_comb begin
        adv_o   = tick_i && (state_q != PIM_IDLE);
        irq_o   = irq_q;
        state_o = state_q;
    end
endmodule

// File: rtl/pim_periodic_irq.sv
module pim_periodic_irq
    import pim_pkg::*;
#(
    parameter int CNT_W = PIM_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic             rd_en_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] rdata_o,
    output logic             irq_o
);
    logic [CNT_W-1:0] eff_mod;
    logic             eff_zero;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_zero;
    logic             match;
    logic             wrap;
    logic             adv;
    pim_state_e       state_q;

    pim_modreg #(.W(CNT_W)) u_modreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wdata_i   (wdata_i),
        .eff_mod_o (eff_mod),
        .eff_zero_o(eff_zero)
    );

    pim_counter #(.W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_i     (adv),
        .eff_mod_i (eff_mod),
        .eff_zero_i(eff_zero),
        .cnt_o     (cnt_q),
        .cnt_zero_o(cnt_zero),
        .match_o   (match),
        .wrap_o    (wrap)
    );

    pim_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .eff_zero_i(eff_zero),
        .cnt_zero_i(cnt_zero),
        .match_i   (match),
        .wrap_i    (wrap),
        .state_o   (state_q),
        .adv_o     (adv),
        .irq_o     (irq_o)
    );

    assign rdata_o = rd_en_i ? cnt_q : '0;
endmodule

// File: rtl/pim_periodic_irq_chk.sv
module pim_periodic_irq_chk
    import pim_pkg::*;
#(
    parameter int CNT_W = PIM_CNT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             wr_en_i,
    input logic [CNT_W-1:0] wdata_i,
    input logic [CNT_W-1:0] cnt_q,
    input pim_state_e       state_q,
    input logic             irq_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_q));

    assert_step_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && state_q != PIM_IDLE) |=> (cnt_q == $past(cnt_q) + ONE || cnt_q == '0));

    assert_irq_after_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(tick_i) && cnt_q == '0));

    assert_idle_parked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PIM_IDLE) |-> (cnt_q == '0));

    assert_zero_write_silences_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wdata_i == '0) |=> !irq_o);
endmodule

bind pim_periodic_irq pim_periodic_irq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .wr_en_i(wr_en_i),
    .wdata_i(wdata_i),
    .cnt_q  (cnt_q),
    .state_q(state_q),
    .irq_o  (irq_o)
);

// File: tb/pim_periodic_irq_bench.sv
module pim_periodic_irq_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic       rd_en_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pim_periodic_irq u_pim_periodic_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .wr_en_i(wr_en_i),
        .rd_en_i(rd_en_i),
        .wdata_i(wdata_i),
        .rdata_o(rdata_o),
        .irq_o  (irq_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present inputs for one cycle; returns at the next falling edge.
    task automatic step(input logic t, input logic w, input logic [7:0] d);
        tick_i = t; wr_en_i = w; wdata_i = d;
        @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0; wdata_i = '0;
    endtask

    task automatic read_cnt(output int v);
        rd_en_i = 1'b1;
        #1 v = rdata_o;
        rd_en_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        int v;
        do_reset();
        read_cnt(v);
        check("R1 count", v, 0);
        check("R1 irq", irq_o, 0);
        #1 check("R2 idle rdata", rdata_o, 0);
    endtask

    task automatic t_idle();
        int v;
        int seen = 0;
        do_reset();
        for (int i = 0; i < 5; i++) begin
            step(1, 0, 0);
            if (irq_o) seen++;
        end
        read_cnt(v);
        check("R5 count", v, 0);
        check("R5 irq", seen, 0);
    endtask

    task automatic t_period();
        int v;
        do_reset();
        step(0, 1, 8'd3);
        for (int p = 0; p < 2; p++) begin
            step(1, 0, 0); read_cnt(v);
            check("R3 count 1", v, 1); check("R4 no irq", irq_o, 0);
            step(0, 0, 0); read_cnt(v);
            check("R3 hold", v, 1);
            step(1, 0, 0); read_cnt(v);
            check("R3 count 2", v, 2);
            step(1, 0, 0); read_cnt(v);
            check("R4 irq", irq_o, 1); check("R4 cleared", v, 0);
            step(0, 0, 0);
            check("R4 pulse width", irq_o, 0);
        end
        step(0, 1, 8'd9); read_cnt(v);
        check("R2 write keeps count", v, 0);
    endtask

    task automatic t_mod1();
        int v;
        do_reset();
        step(0, 1, 8'd1);
        for (int i = 0; i < 3; i++) begin
            step(1, 0, 0); read_cnt(v);
            check("R10 irq", irq_o, 1); check("R10 count", v, 0);
        end
    endtask

    task automatic t_retarget();
        int v;
        int first = -1;
        do_reset();
        step(0, 1, 8'd10);
        for (int i = 0; i < 6; i++) step(1, 0, 0);
        step(0, 1, 8'd4); read_cnt(v);
        check("R8 no clear", v, 6);
        for (int i = 1; i <= 260; i++) begin
            step(1, 0, 0);
            if (irq_o && first < 0) first = i;
        end
        check("R8 wrap tick", first, 254);
    endtask

    task automatic t_stop();
        int v;
        int seen = 0;
        do_reset();
        step(0, 1, 8'd5);
        step(1, 0, 0); step(1, 0, 0);
        step(1, 1, 8'd0); read_cnt(v);
        check("R6 still counts", v, 3);
        check("R6 no irq", irq_o, 0);
        for (int i = 0; i < 252; i++) begin
            step(1, 0, 0);
            if (irq_o) seen++;
        end
        read_cnt(v);
        check("R6 before wrap", v, 255);
        step(1, 0, 0); read_cnt(v);
        check("R6 wrapped", v, 0);
        for (int i = 0; i < 5; i++) begin
            step(1, 0, 0);
            if (irq_o) seen++;
        end
        read_cnt(v);
        check("R6 parked", v, 0);
        check("R6 irq count", seen, 0);
    endtask

    task automatic t_stop_zero();
        int v;
        do_reset();
        step(0, 1, 8'd3);
        for (int i = 0; i < 3; i++) step(1, 0, 0);
        check("R4 irq before stop", irq_o, 1);
        step(0, 1, 8'd0);
        for (int i = 0; i < 4; i++) step(1, 0, 0);
        read_cnt(v);
        check("R7 stopped", v, 0);
    endtask

    task automatic t_resume();
        int v;
        do_reset();
        step(0, 1, 8'd5);
        step(1, 0, 0); step(1, 0, 0);
        step(0, 1, 8'd0);
        for (int i = 0; i < 3; i++) begin
            step(1, 0, 0);
            check("R6 drain no irq", irq_o, 0);
        end
        step(0, 1, 8'd7); read_cnt(v);
        check("R9 kept", v, 5);
        step(1, 0, 0); read_cnt(v);
        check("R9 advance", v, 6);
        step(1, 0, 0); read_cnt(v);
        check("R9 irq", irq_o, 1); check("R9 cleared", v, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_idle();
        t_period();
        t_mod1();
        t_retarget();
        t_stop();
        t_stop_zero();
        t_resume();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule